// File: doc/BRIEF.md
# Video Timing Mode and Format Controller

This block is the control state machine of a video clock and timing generator. Right after reset release it takes one snapshot of three configuration inputs: a 6-bit video format select, a 3-bit audio sample-rate select and a pin that forbids reference locking. From that snapshot and from a live reference-present flag it picks one of three operating modes: free-running from the local crystal, genlock (tracking an external reference), or freeze (holding the last frequency after the reference disappears).

A small write port lets a host program a bank of eight custom timing registers. The block does not store their contents, because the timing counters lie outside it. It only tracks which of the eight have been written, so that it can tell the timing logic when to stop using the built-in default timing. It also filters short dropouts of the reference flag, and it qualifies the phase detector's lock flag over a programmable run of cycles before it reports lock.

Top module: `vtg_mode_ctrl`

## Requirements
- R1: While reset is asserted, and until the first clock edge after its release, `op_mode` is 0 (free-run), `fmt_code` is 0, `use_defaults` is 1, `audio_en` is 0 and `ref_locked` is 0.
- R2: `fmt_sel`, `arate_sel` and `no_lock_pin` are captured at the first clock edge after reset release. Later changes on them do not affect the outputs until the next reset.
- R3: If the captured `no_lock_pin` is 1, `op_mode` stays 0 (free-run) whatever `ref_ok` does, and `ref_locked` stays 0.
- R4: If the captured pin is 0 and the filtered reference is present, `op_mode` becomes 1 (genlock) one edge after the filtered flag rises. The filtered flag rises at the first edge that samples `ref_ok` high. With a preset format selected, `use_defaults` is then 0.
- R5: If the captured pin is 0 and no reference has been seen yet, `op_mode` is 0 and `use_defaults` is 1.
- R6: In genlock, a low run of `ref_ok` shorter than `DEB_CYCLES` cycles (default 4) is ignored. A run of exactly `DEB_CYCLES` cycles clears the filtered flag at its last edge, and `op_mode` becomes 2 (freeze) at the next edge. In freeze, `fmt_code` is kept and `use_defaults` stays 0.
- R7: In freeze, a returning reference moves `op_mode` back to 1 (genlock) at the second edge that samples `ref_ok` high.
- R8: `ref_locked` rises only in genlock, at the `LOCK_CYCLES`-th consecutive edge (default 8) that samples `pd_lock` high while `op_mode` is 1. It falls at the first edge that samples `pd_lock` low, and it is forced to 0 outside genlock.
- R9: Format code 62 selects custom timing. `use_defaults` stays 1 until every address from 0x4E to 0x55 has been written at least once since reset. Writes to other addresses, and repeated writes, do not complete the set.
- R10: Format codes 0, 52 to 61 and 63 are reserved and keep `use_defaults` at 1 in every mode. Codes 1 to 51 are presets.
- R11: Audio rate code 0 turns audio off (`audio_en` is 0). Codes 1 to 7 set `audio_en` to 1 and appear unchanged on `audio_rate`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_sel | input | 6 | Video format select, captured once after reset |
| arate_sel | input | 3 | Audio sample-rate select, captured once after reset |
| no_lock_pin | input | 1 | 1 forces free-run, captured once after reset |
| ref_ok | input | 1 | Reference present flag (unfiltered) |
| pd_lock | input | 1 | Lock flag from the external phase detector |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 8 | Host register write address |
| op_mode | output | 2 | 0 free-run, 1 genlock, 2 freeze |
| fmt_code | output | 6 | Captured format code |
| use_defaults | output | 1 | Internal default timing governs the outputs |
| audio_en | output | 1 | Audio clock generation enabled |
| audio_rate | output | 3 | Captured audio rate code |
| ref_locked | output | 1 | Qualified lock indication |

## Verification
The bench goes after the exact edge on which freeze is entered. It drops the reference for one cycle fewer than the debounce count, which a design with an off-by-one filter would turn into a spurious freeze, and then for the full count, where a late or early transition is caught at the edge. Lock qualification is checked at its exact edge, both from startup and after a one-cycle lock dropout. A counter that does not restart would report lock too early. For the custom format, the bench writes addresses just outside the bank and repeats a write. A design that counts writes instead of tracking addresses would release the defaults too soon. The bench also changes the selects after capture and toggles the reference under the free-run pin, where a design that re-samples or ignores the pin changes its outputs.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  typedef enum logic [1:0] {
    VM_FREE    = 2'b00,
    VM_GENLOCK = 2'b01,
    VM_FREEZE  = 2'b10
  } vmode_e;
endpackage

// File: rtl/vtg_ref_filter.sv
// Reference-present filter: rises at once, falls only after DEB consecutive low samples.
module vtg_ref_filter #(
  parameter int DEB = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  output logic ref_good
);
  localparam int CW = $clog2(DEB + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          good_q, good_d;

  always_comb begin
    cnt_d  = cnt_q;
    good_d = good_q;
    if (ref_in) begin
      cnt_d  = '0;
      good_d = 1'b1;
    end else if (good_q) begin
      if (cnt_q == CW'(DEB - 1)) begin
        cnt_d  = '0;
        good_d = 1'b0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      good_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      good_q <= good_d;
    end
  end

  assign ref_good = good_q;
endmodule

// File: rtl/vtg_lock_qual.sv
// Lock qualifier: asserts after LOCK consecutive enabled samples of pd_lock.
module vtg_lock_qual #(
  parameter int LOCK = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic pd_lock,
  output logic locked
);
  localparam int CW = $clog2(LOCK + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          lk_q, lk_d;

  always_comb begin
    cnt_d = cnt_q;
    lk_d  = lk_q;
    if (!enable || !pd_lock) begin
      cnt_d = '0;
      lk_d  = 1'b0;
    end else if (!lk_q) begin
      if (cnt_q == CW'(LOCK - 1)) begin
        lk_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lk_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      lk_q  <= lk_d;
    end
  end

  assign locked = lk_q;
endmodule

// File: rtl/vtg_cust_mask.sv
// Tracks which registers of the custom timing bank have been written.
module vtg_cust_mask #(
  parameter int ADDR_W = 8,
  parameter int BASE   = 'h4E,
  parameter int NREG   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [NREG-1:0]   mask,
  output logic              all_done
);
  logic [NREG-1:0] hit;
  logic [NREG-1:0] mask_q, mask_d;

  for (genvar i = 0; i < NREG; i++) begin : g_hit
    assign hit[i] = wr_en && (wr_addr == ADDR_W'(BASE + i));
  end

  always_comb begin
    if (clear) mask_d = '0;
    else       mask_d = mask_q | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  assign mask     = mask_q;
  assign all_done = &mask_q;
endmodule

// File: rtl/vtg_mode_ctrl.sv
module vtg_mode_ctrl #(
  parameter int STD_W       = 6,
  parameter int AR_W        = 3,
  parameter int ADDR_W      = 8,
  parameter int PRESET_MAX  = 51,
  parameter int CUSTOM_CODE = 62,
  parameter int CUST_BASE   = 'h4E,
  parameter int CUST_NREG   = 8,
  parameter int DEB_CYCLES  = 4,
  parameter int LOCK_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STD_W-1:0]  fmt_sel,
  input  logic [AR_W-1:0]   arate_sel,
  input  logic              no_lock_pin,
  input  logic              ref_ok,
  input  logic              pd_lock,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [1:0]        op_mode,
  output logic [STD_W-1:0]  fmt_code,
  output logic              use_defaults,
  output logic              audio_en,
  output logic [AR_W-1:0]   audio_rate,
  output logic              ref_locked
);
  import vtg_pkg::*;

  // configuration snapshot
  logic             sampled_q;
  logic [STD_W-1:0] std_q;
  logic [AR_W-1:0]  arate_q;
  logic             pin_q;
  logic             cap_en;

  assign cap_en = !sampled_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sampled_q <= 1'b0;
      std_q     <= '0;
      arate_q   <= '0;
      pin_q     <= 1'b0;
    end else if (cap_en) begin
      sampled_q <= 1'b1;
      std_q     <= fmt_sel;
      arate_q   <= arate_sel;
      pin_q     <= no_lock_pin;
    end
  end

  // sub-blocks
  logic                 ref_good;
  logic                 lock_raw;
  logic [CUST_NREG-1:0] cust_mask;
  logic                 cust_done;
  vmode_e               mode_q, mode_d;

  vtg_ref_filter #(.DEB(DEB_CYCLES)) u_ref (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_in   (ref_ok),
    .ref_good (ref_good)
  );

  vtg_lock_qual #(.LOCK(LOCK_CYCLES)) u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (mode_q == VM_GENLOCK),
    .pd_lock (pd_lock),
    .locked  (lock_raw)
  );

  vtg_cust_mask #(.ADDR_W(ADDR_W), .BASE(CUST_BASE), .NREG(CUST_NREG)) u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (!sampled_q),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .mask     (cust_mask),
    .all_done (cust_done)
  );

  // mode state machine
  always_comb begin
    mode_d = mode_q;
    if (sampled_q) begin
      if (pin_q) begin
        mode_d = VM_FREE;
      end else begin
        unique case (mode_q)
          VM_FREE:    if (ref_good)  mode_d = VM_GENLOCK;
          VM_GENLOCK: if (!ref_good) mode_d = VM_FREEZE;
          VM_FREEZE:  if (ref_good)  mode_d = VM_GENLOCK;
          default:                   mode_d = VM_FREE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= VM_FREE;
    else        mode_q <= mode_d;
  end

  // outputs
  logic is_preset, is_custom, fmt_ok, no_ref_yet;

  assign is_preset  = (std_q >= STD_W'(1)) && (std_q <= STD_W'(PRESET_MAX));
  assign is_custom  = (std_q == STD_W'(CUSTOM_CODE));
  assign fmt_ok     = is_preset || (is_custom && cust_done);
  assign no_ref_yet = !pin_q && (mode_q == VM_FREE);

  assign op_mode      = mode_q;
  assign fmt_code     = std_q;
  assign use_defaults = !sampled_q || !fmt_ok || no_ref_yet;
  assign audio_en     = sampled_q && (arate_q != '0);
  assign audio_rate   = arate_q;
  assign ref_locked   = lock_raw && (mode_q == VM_GENLOCK);
endmodule

// File: rtl/vtg_mode_ctrl_chk.sv
module vtg_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] op_mode,
  input logic [5:0] fmt_code,
  input logic       use_defaults,
  input logic       audio_en,
  input logic [2:0] audio_rate,
  input logic       ref_locked,
  input logic       pd_lock,
  input logic       sampled,
  input logic       pin_hi,
  input logic [7:0] cust_mask
);
  import vtg_pkg::*;

  assert_fmt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sampled && $past(sampled)) |-> $stable(fmt_code));

  assert_freerun_pin_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sampled && pin_hi) |-> (op_mode == VM_FREE && !ref_locked));

  assert_genlock_pin_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_mode == VM_GENLOCK) |-> !pin_hi);

  assert_freeze_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_mode == VM_FREEZE && $past(op_mode) != VM_FREEZE) |-> $past(op_mode) == VM_GENLOCK);

  assert_freeze_keeps_fmt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_mode == VM_FREEZE) |-> $stable(fmt_code));

  assert_lock_needs_pd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ref_locked |-> $past(pd_lock));

  assert_custom_defaults_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sampled && fmt_code == 6'd62 && cust_mask != 8'hFF) |-> use_defaults);

  assert_audio_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
    audio_en |-> (audio_rate != 3'd0));
endmodule

bind vtg_mode_ctrl vtg_mode_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .op_mode      (op_mode),
  .fmt_code     (fmt_code),
  .use_defaults (use_defaults),
  .audio_en     (audio_en),
  .audio_rate   (audio_rate),
  .ref_locked   (ref_locked),
  .pd_lock      (pd_lock),
  .sampled      (sampled_q),
  .pin_hi       (pin_q),
  .cust_mask    (cust_mask)
);

// File: tb/vtg_mode_ctrl_bench.sv
module vtg_mode_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEB  = 4;
  localparam int LOCK = 8;

  logic       clk, rst_n;
  logic [5:0] fmt_sel;
  logic [2:0] arate_sel;
  logic       no_lock_pin, ref_ok, pd_lock, wr_en;
  logic [7:0] wr_addr;
  logic [1:0] op_mode;
  logic [5:0] fmt_code;
  logic       use_defaults, audio_en, ref_locked;
  logic [2:0] audio_rate;

  int n_chk = 0;
  int n_bad = 0;

  vtg_mode_ctrl u_vtg_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .arate_sel(arate_sel),
    .no_lock_pin(no_lock_pin), .ref_ok(ref_ok), .pd_lock(pd_lock),
    .wr_en(wr_en), .wr_addr(wr_addr), .op_mode(op_mode), .fmt_code(fmt_code),
    .use_defaults(use_defaults), .audio_en(audio_en), .audio_rate(audio_rate),
    .ref_locked(ref_locked)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // inputs are changed on the falling edge; outputs are read there as well
  task automatic do_reset(input int fs, input int ar, input int pin, input int rf, input int pl);
    @(negedge clk);
    rst_n = 1'b0; fmt_sel = 6'(fs); arate_sel = 3'(ar); no_lock_pin = pin[0];
    ref_ok = rf[0]; pd_lock = pl[0]; wr_en = 1'b0; wr_addr = '0;
    step(3);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_r1;
    do_reset(10, 5, 0, 1, 1);
    chk("R1 mode",     op_mode, 0);
    chk("R1 fmt",      fmt_code, 0);
    chk("R1 defaults", use_defaults, 1);
    chk("R1 audio_en", audio_en, 0);
    chk("R1 locked",   ref_locked, 0);
  endtask

  task automatic t_freerun_r3;
    do_reset(10, 0, 1, 1, 1);
    step(1);
    chk("R3 mode",     op_mode, 0);
    chk("R3 fmt",      fmt_code, 10);
    chk("R3 defaults", use_defaults, 0);
    chk("R11 audio off", audio_en, 0);
    ref_ok = 1'b0; step(6); ref_ok = 1'b1; step(12);
    chk("R3 mode after ref toggle", op_mode, 0);
    chk("R3 never locked", ref_locked, 0);
    fmt_sel = 6'd20; arate_sel = 3'd4; no_lock_pin = 1'b0; step(3);
    chk("R2 fmt held",   fmt_code, 10);
    chk("R2 audio held", audio_en, 0);
    chk("R2 pin held",   op_mode, 0);
  endtask

  task automatic t_genlock_r4_r6_r7_r8;
    do_reset(30, 5, 0, 1, 1);
    step(1);
    chk("R4 mode edge1", op_mode, 0);
    step(1);
    chk("R4 mode genlock", op_mode, 1);
    chk("R4 defaults",     use_defaults, 0);
    chk("R4 fmt",          fmt_code, 30);
    chk("R11 audio_en",    audio_en, 1);
    chk("R11 audio_rate",  audio_rate, 5);
    step(LOCK - 1);
    chk("R8 not yet locked", ref_locked, 0);
    step(1);
    chk("R8 locked", ref_locked, 1);
    pd_lock = 1'b0; step(1);
    chk("R8 drop on pd low", ref_locked, 0);
    pd_lock = 1'b1; step(LOCK - 1);
    chk("R8 relock too early", ref_locked, 0);
    step(1);
    chk("R8 relocked", ref_locked, 1);
    ref_ok = 1'b0; step(DEB - 1); ref_ok = 1'b1;
    chk("R6 glitch mode", op_mode, 1);
    step(3);
    chk("R6 glitch ignored", op_mode, 1);
    chk("R6 lock kept",      ref_locked, 1);
    ref_ok = 1'b0; step(DEB);
    chk("R6 still genlock", op_mode, 1);
    step(1);
    chk("R6 freeze",          op_mode, 2);
    chk("R6 freeze unlocked", ref_locked, 0);
    chk("R6 freeze defaults", use_defaults, 0);
    chk("R6 freeze fmt",      fmt_code, 30);
    step(10);
    chk("R6 freeze held", op_mode, 2);
    ref_ok = 1'b1; step(1);
    chk("R7 one edge", op_mode, 2);
    step(1);
    chk("R7 back to genlock", op_mode, 1);
    step(LOCK - 1);
    chk("R8 after freeze early", ref_locked, 0);
    step(1);
    chk("R8 after freeze", ref_locked, 1);
  endtask

  task automatic t_noref_r5;
    do_reset(12, 2, 0, 0, 0);
    step(3);
    chk("R5 mode",     op_mode, 0);
    chk("R5 defaults", use_defaults, 1);
    chk("R5 fmt",      fmt_code, 12);
    ref_ok = 1'b1; step(1);
    chk("R4 late ref edge1", op_mode, 0);
    step(1);
    chk("R4 late ref genlock", op_mode, 1);
    chk("R4 late ref defaults", use_defaults, 0);
  endtask

  task automatic t_reserved_r10;
    do_reset(55, 1, 0, 1, 0);
    step(3);
    chk("R10 code55 mode",     op_mode, 1);
    chk("R10 code55 defaults", use_defaults, 1);
    do_reset(0, 1, 1, 0, 0);
    step(2);
    chk("R10 code0 defaults", use_defaults, 1);
    do_reset(51, 1, 1, 0, 0);
    step(2);
    chk("R10 code51 preset", use_defaults, 0);
  endtask

  task automatic wr(input int a);
    wr_en = 1'b1; wr_addr = 8'(a); step(1); wr_en = 1'b0;
  endtask

  task automatic t_custom_r9;
    do_reset(62, 7, 1, 0, 0);
    step(1);
    chk("R9 start defaults", use_defaults, 1);
    chk("R11 rate7", audio_rate, 7);
    for (int a = 'h4E; a <= 'h54; a++) wr(a);
    wr('h4D); wr('h56); wr('h50); wr('h4E);
    chk("R9 seven of eight", use_defaults, 1);
    wr('h55);
    chk("R9 all written", use_defaults, 0);
    do_reset(62, 7, 1, 0, 0);
    step(2);
    chk("R9 cleared by reset", use_defaults, 1);
  endtask

  initial begin
    rst_n = 1'b0; fmt_sel = '0; arate_sel = '0; no_lock_pin = 1'b0;
    ref_ok = 1'b0; pd_lock = 1'b0; wr_en = 1'b0; wr_addr = '0;
    t_reset_r1();
    t_freerun_r3();
    t_genlock_r4_r6_r7_r8();
    t_noref_r5();
    t_reserved_r10();
    t_custom_r9();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule